// File: doc/BRIEF.md
# Pixel Clock Divider Search Engine

This block finds a pair of integer dividers for a clock synthesizer whose output frequency is `f_ref * N / M`. When started, it takes a requested frequency, bounds it between a lower oscillator limit and an upper clock limit, and sweeps the reference divider M over the range that the selected device class allows. For each M it computes the nearest feedback multiplier N by integer rounding and keeps the pair with the smallest absolute frequency error. All frequencies are unsigned integers in one common unit, such as kHz.

After the sweep, the block converts the winning pair into three register bytes and computes the frequency that the pair actually gives. Large reference divisors are reached through a divide-by-two prescaler bit, so only even M values are allowed in the upper half of the range. One shared sequential restoring divider does every division, so each candidate costs a fixed number of cycles. A one-cycle `done` pulse marks the result. An error flag raised with `done` reports that no candidate fits the N range.

Top module: `pll_div_search`

## Requirements
- R1: On start the working frequency f is the request raised to `vco_min_khz_i` if it is below that value, and then lowered to `clk_max_khz_i` if it is above that value. All later steps use f in place of the request.
- R2: `dev_class_i` sets the limits: 0 gives M_max=32 and N_max=128; 1 gives M_max=64 and N_max=128; 2 and 3 give M_max=64 and N_max=2048.
- R3: M runs upward from 1 to M_max. Odd values of M above M_max/2 are never chosen.
- R4: For each M, N = floor((2*f*M + f_ref) / (2*f_ref)), which is f*M/f_ref rounded half up. A candidate with N = 0 or N > N_max is dropped.
- R5: A candidate's error is |f - f_ref*N/M|. A candidate replaces the stored best only when its error is strictly smaller, so on a tie the smaller M is kept.
- R6: The programmed N is N_best-1. If M_best <= M_max/2, then `m_reg_o` = M_best-1 and the prescaler flag is 0. Otherwise `m_reg_o` = M_best/2-1 and the prescaler flag is 1.
- R7: For classes 0 and 1, `n_lo_reg_o` = {prescaler, programmed N[6:0]} and `n_hi_reg_o` = 0.
- R8: For classes 2 and 3, `n_lo_reg_o` = programmed N[7:0] and `n_hi_reg_o` = {prescaler, programmed N[10:8], 4'b0000}.
- R9: `achieved_khz_o` = floor(f_ref*N_best/M_best).
- R10: `done_o` is high for exactly one cycle per search. The outputs change only in that cycle.
- R11: If no candidate survives, `err_o` and `done_o` go high together and the register bytes and the achieved frequency keep their previous values. On a successful search, `err_o` is 0 during `done_o`.
- R12: The inputs are captured when start is accepted. A start pulse or an input change during a search has no effect on that search.
- R13: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a search when the block is idle |
| req_khz_i | input | FREQ_W | Requested output frequency |
| fref_khz_i | input | FREQ_W | Reference frequency, nonzero |
| vco_min_khz_i | input | FREQ_W | Lower frequency bound |
| clk_max_khz_i | input | FREQ_W | Upper frequency bound |
| dev_class_i | input | 2 | Device class selecting the limits |
| done_o | output | 1 | One-cycle result pulse |
| err_o | output | 1 | No valid candidate, valid with done_o |
| m_reg_o | output | 8 | Programmed reference divider byte |
| n_lo_reg_o | output | 8 | Low feedback register byte |
| n_hi_reg_o | output | 8 | High feedback register byte |
| achieved_khz_o | output | FREQ_W+1 | Frequency given by the chosen pair |

## Verification
Exact-match inputs check tie handling. A design that used a non-strict comparison would move to a later, larger M with the same error and report a different M byte. Requests whose only exact divisors lie in the upper M range check the prescaler encoding and the skipping of odd M. An error in either would show as a wrong prescaler bit or an odd M being chosen. A maximal N on the wide class checks the split of N across the two bytes. Clamping in both directions, a search in which every N is out of range (the outputs must stay frozen), and a start pulse sent during a search complete the corner cases, and several general requests are compared against an arithmetic model.

// File: rtl/pll_srch_pkg.sv
package pll_srch_pkg;

    typedef enum logic [1:0] {
        CLS_GEN1  = 2'd0,
        CLS_GEN2  = 2'd1,
        CLS_GEN3  = 2'd2,
        CLS_GEN3B = 2'd3
    } dev_cls_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PICK,
        ST_WAIT,
        ST_ACH,
        ST_AWAIT
    } srch_st_e;

    typedef struct packed {
        logic [7:0] m_byte;
        logic [7:0] n_lo;
        logic [7:0] n_hi;
    } pll_regs_t;

    function automatic int unsigned m_limit(dev_cls_e c);
        return (c == CLS_GEN1) ? 32 : 64;
    endfunction

    function automatic int unsigned n_limit(dev_cls_e c);
        return (c == CLS_GEN1 || c == CLS_GEN2) ? 128 : 2048;
    endfunction

    function automatic logic wide_n(dev_cls_e c);
        return (c == CLS_GEN3 || c == CLS_GEN3B);
    endfunction

endpackage

// File: rtl/pll_seq_div.sv
module pll_seq_div #(
    parameter int NUM_W = 32,
    parameter int DEN_W = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             valid_o,
    output logic [NUM_W-1:0] quo_o
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] num_sh_q, num_cap_q, quo_q;
    logic [DEN_W-1:0] den_q, rem_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q, valid_q;

    logic [DEN_W:0]   rem_sh;
    logic             fits;
    logic [DEN_W-1:0] rem_nx;

    always_comb begin
        rem_sh = {rem_q, num_sh_q[NUM_W-1]};
        fits   = rem_sh >= {1'b0, den_q};
        rem_nx = fits ? DEN_W'(rem_sh - {1'b0, den_q}) : rem_sh[DEN_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            num_sh_q  <= '0;
            num_cap_q <= '0;
            quo_q     <= '0;
            den_q     <= '0;
            rem_q     <= '0;
            cnt_q     <= '0;
            busy_q    <= 1'b0;
            valid_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (start_i && !busy_q) begin
                num_sh_q  <= num_i;
                num_cap_q <= num_i;
                den_q     <= den_i;
                rem_q     <= '0;
                quo_q     <= '0;
                cnt_q     <= CNT_W'(NUM_W);
                busy_q    <= 1'b1;
            end else if (busy_q) begin
                rem_q    <= rem_nx;
                quo_q    <= {quo_q[NUM_W-2:0], fits};
                num_sh_q <= num_sh_q << 1;
                cnt_q    <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy_q  <= 1'b0;
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign valid_o = valid_q;
    assign quo_o   = quo_q;

    // R4: quotient and remainder reconstruct the captured dividend
    assert_div_exact_R4: assert property (@(posedge clk) disable iff (rst)
        (valid_q && den_q != '0) |->
            (64'(quo_q) * 64'(den_q) + 64'(rem_q) == 64'(num_cap_q)) && (rem_q < den_q));

    // R10: the divider result strobe lasts a single cycle
    assert_div_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);

endmodule

// File: rtl/pll_cand_eval.sv
module pll_cand_eval #(
    parameter int FREQ_W = 20,
    parameter int M_W    = 7,
    parameter int N_W    = 11,
    parameter int NUM_W  = 32
) (
    input  logic [NUM_W-1:0]       quo_i,
    input  logic [M_W-1:0]         m_i,
    input  logic [FREQ_W-1:0]      f_i,
    input  logic [FREQ_W-1:0]      fref_i,
    input  logic [N_W:0]           nmax_i,
    input  logic                   found_i,
    input  logic [FREQ_W+N_W:0]    best_err_i,
    input  logic [M_W-1:0]         best_m_i,
    output logic                   accept_o,
    output logic [N_W:0]           n_o,
    output logic [FREQ_W+N_W:0]    err_o
);
    localparam int ERR_W = FREQ_W + N_W + 1;
    localparam int CMP_W = ERR_W + M_W;

    logic             in_range, better;
    logic [ERR_W-1:0] lhs_f, rhs_f;
    logic [CMP_W-1:0] cand_x, best_x;

    always_comb begin
        in_range = (quo_i != '0) && (quo_i <= NUM_W'(nmax_i));
        n_o      = quo_i[N_W:0];
        lhs_f    = ERR_W'(f_i) * ERR_W'(m_i);
        rhs_f    = ERR_W'(fref_i) * ERR_W'(n_o);
        err_o    = (lhs_f >= rhs_f) ? (lhs_f - rhs_f) : (rhs_f - lhs_f);
        cand_x   = CMP_W'(err_o) * CMP_W'(best_m_i);
        best_x   = CMP_W'(best_err_i) * CMP_W'(m_i);
        better   = !found_i || (cand_x < best_x);
        accept_o = in_range && better;
    end

endmodule

// File: rtl/pll_reg_pack.sv
module pll_reg_pack
    import pll_srch_pkg::*;
#(
    parameter int M_W = 7,
    parameter int N_W = 11
) (
    input  dev_cls_e        cls_i,
    input  logic [M_W-1:0]  mmax_i,
    input  logic [M_W-1:0]  best_m_i,
    input  logic [N_W:0]    best_n_i,
    output pll_regs_t       regs_o
);
    logic           pre;
    logic [M_W-1:0] pm;
    logic [N_W-1:0] pn;

    always_comb begin
        pre = best_m_i > (mmax_i >> 1);
        pm  = pre ? ((best_m_i >> 1) - 1'b1) : (best_m_i - 1'b1);
        pn  = N_W'(best_n_i - 1'b1);
        regs_o.m_byte = 8'(pm);
        if (wide_n(cls_i)) begin
            regs_o.n_lo = pn[7:0];
            regs_o.n_hi = {pre, pn[N_W-1:8], 4'b0000};
        end else begin
            regs_o.n_lo = {pre, pn[6:0]};
            regs_o.n_hi = 8'h00;
        end
    end

endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
    import pll_srch_pkg::*;
#(
    parameter int FREQ_W = 20,
    parameter int M_W    = 7,
    parameter int N_W    = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [FREQ_W-1:0] req_khz_i,
    input  logic [FREQ_W-1:0] fref_khz_i,
    input  logic [FREQ_W-1:0] vco_min_khz_i,
    input  logic [FREQ_W-1:0] clk_max_khz_i,
    input  logic [1:0]        dev_class_i,
    output logic              done_o,
    output logic              err_o,
    output logic [7:0]        m_reg_o,
    output logic [7:0]        n_lo_reg_o,
    output logic [7:0]        n_hi_reg_o,
    output logic [FREQ_W:0]   achieved_khz_o
);
    localparam int NUM_W = FREQ_W + 12;
    localparam int DEN_W = FREQ_W + 1;
    localparam int ERR_W = FREQ_W + N_W + 1;

    srch_st_e          st_q;
    dev_cls_e          cls_q;
    logic [FREQ_W-1:0] f_q, fref_q;
    logic [M_W-1:0]    mmax_q, m_q, best_m_q;
    logic [N_W:0]      nmax_q, best_n_q;
    logic [ERR_W-1:0]  best_err_q;
    logic              found_q;
    logic              done_q, err_q;
    pll_regs_t         regs_q;
    logic [FREQ_W:0]   ach_q;

    logic [FREQ_W-1:0] f_lo, f_clamped;
    logic              m_over, m_skip;
    logic              div_start, div_valid;
    logic [NUM_W-1:0]  div_num, div_quo;
    logic [DEN_W-1:0]  div_den;
    logic              cand_ok;
    logic [N_W:0]      cand_n;
    logic [ERR_W-1:0]  cand_err;
    pll_regs_t         regs_nx;

    always_comb begin
        f_lo      = (req_khz_i < vco_min_khz_i) ? vco_min_khz_i : req_khz_i;
        f_clamped = (f_lo > clk_max_khz_i) ? clk_max_khz_i : f_lo;
        m_over    = m_q > mmax_q;
        m_skip    = (m_q > (mmax_q >> 1)) && m_q[0];
        div_start = 1'b0;
        div_num   = '0;
        div_den   = '0;
        if (st_q == ST_PICK && !m_over && !m_skip) begin
            div_start = 1'b1;
            div_num   = ((NUM_W'(f_q) * NUM_W'(m_q)) << 1) + NUM_W'(fref_q);
            div_den   = {fref_q, 1'b0};
        end else if (st_q == ST_ACH) begin
            div_start = 1'b1;
            div_num   = NUM_W'(fref_q) * NUM_W'(best_n_q);
            div_den   = DEN_W'(best_m_q);
        end
    end

    pll_seq_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .start_i (div_start),
        .num_i   (div_num),
        .den_i   (div_den),
        .valid_o (div_valid),
        .quo_o   (div_quo)
    );

    pll_cand_eval #(.FREQ_W(FREQ_W), .M_W(M_W), .N_W(N_W), .NUM_W(NUM_W)) u_eval (
        .quo_i      (div_quo),
        .m_i        (m_q),
        .f_i        (f_q),
        .fref_i     (fref_q),
        .nmax_i     (nmax_q),
        .found_i    (found_q),
        .best_err_i (best_err_q),
        .best_m_i   (best_m_q),
        .accept_o   (cand_ok),
        .n_o        (cand_n),
        .err_o      (cand_err)
    );

    pll_reg_pack #(.M_W(M_W), .N_W(N_W)) u_pack (
        .cls_i    (cls_q),
        .mmax_i   (mmax_q),
        .best_m_i (best_m_q),
        .best_n_i (best_n_q),
        .regs_o   (regs_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            cls_q      <= CLS_GEN1;
            f_q        <= '0;
            fref_q     <= '0;
            mmax_q     <= '0;
            nmax_q     <= '0;
            m_q        <= '0;
            best_m_q   <= '0;
            best_n_q   <= '0;
            best_err_q <= '0;
            found_q    <= 1'b0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            regs_q     <= '0;
            ach_q      <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        cls_q   <= dev_cls_e'(dev_class_i);
                        f_q     <= f_clamped;
                        fref_q  <= fref_khz_i;
                        mmax_q  <= M_W'(m_limit(dev_cls_e'(dev_class_i)));
                        nmax_q  <= (N_W+1)'(n_limit(dev_cls_e'(dev_class_i)));
                        m_q     <= M_W'(1);
                        found_q <= 1'b0;
                        st_q    <= ST_PICK;
                    end
                end
                ST_PICK: begin
                    if (m_over) begin
                        if (found_q) begin
                            st_q <= ST_ACH;
                        end else begin
                            done_q <= 1'b1;
                            err_q  <= 1'b1;
                            st_q   <= ST_IDLE;
                        end
                    end else if (m_skip) begin
                        m_q <= m_q + 1'b1;
                    end else begin
                        st_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (div_valid) begin
                        if (cand_ok) begin
                            best_m_q   <= m_q;
                            best_n_q   <= cand_n;
                            best_err_q <= cand_err;
                            found_q    <= 1'b1;
                        end
                        m_q  <= m_q + 1'b1;
                        st_q <= ST_PICK;
                    end
                end
                ST_ACH: st_q <= ST_AWAIT;
                ST_AWAIT: begin
                    if (div_valid) begin
                        regs_q <= regs_nx;
                        ach_q  <= div_quo[FREQ_W:0];
                        done_q <= 1'b1;
                        st_q   <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign done_o         = done_q;
    assign err_o          = err_q;
    assign m_reg_o        = regs_q.m_byte;
    assign n_lo_reg_o     = regs_q.n_lo;
    assign n_hi_reg_o     = regs_q.n_hi;
    assign achieved_khz_o = ach_q;

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    assert_regs_change_on_done_R10: assert property (@(posedge clk) disable iff (rst)
        (!$stable(regs_q) || !$stable(ach_q)) |-> done_q);

    assert_err_with_done_R11: assert property (@(posedge clk) disable iff (rst)
        err_q |-> done_q);

    assert_best_n_in_range_R4: assert property (@(posedge clk) disable iff (rst)
        (done_q && !err_q) |-> (best_n_q != '0) && (best_n_q <= nmax_q));

    assert_upper_m_even_R3: assert property (@(posedge clk) disable iff (rst)
        (done_q && !err_q) |-> ((best_m_q <= (mmax_q >> 1)) || !best_m_q[0]));

endmodule

// File: tb/sim_pll_div_search.sv
module sim_pll_div_search;
    localparam int CLK_PERIOD = 10;
    localparam int FREQ_W     = 20;

    logic              clk = 1'b0;
    logic              rst;
    logic              start;
    logic [FREQ_W-1:0] req, fref, vmin, fmax;
    logic [1:0]        cls;
    logic              done, err;
    logic [7:0]        m_reg, n_lo, n_hi;
    logic [FREQ_W:0]   ach;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_div_search #(.FREQ_W(FREQ_W)) u0 (
        .clk(clk), .rst(rst), .start_i(start),
        .req_khz_i(req), .fref_khz_i(fref),
        .vco_min_khz_i(vmin), .clk_max_khz_i(fmax),
        .dev_class_i(cls),
        .done_o(done), .err_o(err),
        .m_reg_o(m_reg), .n_lo_reg_o(n_lo), .n_hi_reg_o(n_hi),
        .achieved_khz_o(ach)
    );

    task automatic chk(string tag, longint act, longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // expected results from the requirement arithmetic
    task automatic model(input longint rq, input longint fr, input longint vl, input longint vh,
                         input int c, output bit ok, output longint em, output longint enlo,
                         output longint enhi, output longint each);
        longint f, mmax, nmax, bm, bn, be, pn, pm;
        bit pre;
        f = (rq < vl) ? vl : rq;
        if (f > vh) f = vh;
        mmax = (c == 0) ? 32 : 64;
        nmax = (c < 2) ? 128 : 2048;
        ok = 0; bm = 0; bn = 0; be = 0;
        for (longint m = 1; m <= mmax; m++) begin
            longint n, e;
            if (m > mmax/2 && (m % 2) == 1) continue;
            n = (2*f*m + fr) / (2*fr);
            if (n < 1 || n > nmax) continue;
            e = f*m - fr*n;
            if (e < 0) e = -e;
            if (!ok || e*bm < be*m) begin
                ok = 1; bm = m; bn = n; be = e;
            end
        end
        pn  = bn - 1;
        pre = bm > mmax/2;
        pm  = pre ? bm/2 - 1 : bm - 1;
        em  = pm;
        if (c >= 2) begin
            enlo = pn & 255;
            enhi = (longint'(pre) << 7) | (((pn >> 8) & 7) << 4);
        end else begin
            enlo = (longint'(pre) << 7) | (pn & 127);
            enhi = 0;
        end
        each = ok ? (fr*bn)/bm : 0;
    endtask

    task automatic fire(longint rq, longint fr, longint vl, longint vh, int c);
        @(negedge clk);
        req = FREQ_W'(rq); fref = FREQ_W'(fr); vmin = FREQ_W'(vl); fmax = FREQ_W'(vh);
        cls = 2'(c); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(string tag);
        int k = 0;
        while (!done && k < 20000) begin
            @(negedge clk);
            k++;
        end
        chk({tag, " R10 done seen"}, done, 1);
    endtask

    task automatic run_model(string tag, longint rq, longint fr, longint vl, longint vh, int c);
        bit ok; longint em, elo, ehi, ea;
        model(rq, fr, vl, vh, c, ok, em, elo, ehi, ea);
        fire(rq, fr, vl, vh, c);
        wait_done(tag);
        chk({tag, " R11 err"}, err, 0);
        chk({tag, " R6 m byte"}, m_reg, em);
        chk({tag, " R7/R8 n low"}, n_lo, elo);
        chk({tag, " R8 n high"}, n_hi, ehi);
        chk({tag, " R9 achieved"}, ach, ea);
        @(negedge clk);
        chk({tag, " R10 one-cycle done"}, done, 0);
    endtask

    task automatic t_reset;
        chk("R13 reset done", done, 0);
        chk("R13 reset err", err, 0);
        chk("R13 reset m", m_reg, 0);
        chk("R13 reset nlo", n_lo, 0);
        chk("R13 reset nhi", n_hi, 0);
        chk("R13 reset ach", ach, 0);
    endtask

    task automatic t_tie;
        // exact at M=1, later exact multiples tie: R5 keeps M=1
        run_model("R5 tie", 5000, 1000, 100, 900000, 0);
        chk("R5 tie m byte", m_reg, 0);
        chk("R7 tie n low", n_lo, 8'h04);
        chk("R9 tie ach", ach, 5000);
    endtask

    task automatic t_prescale;
        // exact only at M=34 on class 1: prescaler path
        run_model("R3 prescale", 35000, 34000, 100, 900000, 1);
        chk("R6 prescale m byte", m_reg, 16);
        chk("R7 prescale n low", n_lo, 8'hA2);
        chk("R9 prescale ach", ach, 35000);
        // same input on class 0 has M up to 32 only
        run_model("R2 class0", 35000, 34000, 100, 900000, 0);
        // exact divisors at odd M=33 must be skipped
        run_model("R3 odd skip", 34000, 33000, 100, 900000, 1);
    endtask

    task automatic t_wide;
        run_model("R8 wide", 204750, 100, 100, 900000, 2);
        chk("R8 wide n low", n_lo, 8'hFF);
        chk("R8 wide n high", n_hi, 8'h70);
        chk("R9 wide ach", ach, 204800);
        run_model("R2 class3", 204750, 100, 100, 900000, 3);
    endtask

    task automatic t_clamp;
        run_model("R1 low clamp", 100, 1000, 3000, 900000, 0);
        chk("R1 low clamp ach", ach, 3000);
        run_model("R1 high clamp", 50000, 1000, 100, 8000, 1);
        chk("R1 high clamp ach", ach, 8000);
        chk("R1 high clamp nlo", n_lo, 8'h07);
    endtask

    task automatic t_general;
        run_model("R4 gen a", 25175, 14318, 1000, 900000, 0);
        run_model("R4 gen b", 65000, 14318, 1000, 900000, 1);
        run_model("R5 gen c", 108000, 14318, 1000, 900000, 2);
        run_model("R4 gen d", 31500, 27000, 1000, 900000, 2);
    endtask

    task automatic t_error;
        logic [7:0] pm, pl, ph; logic [FREQ_W:0] pa;
        pm = m_reg; pl = n_lo; ph = n_hi; pa = ach;
        fire(1000, 1, 100, 900000, 0);
        wait_done("R11 none valid");
        chk("R11 err flag", err, 1);
        chk("R11 m kept", m_reg, pm);
        chk("R11 nlo kept", n_lo, pl);
        chk("R11 nhi kept", n_hi, ph);
        chk("R11 ach kept", ach, pa);
        @(negedge clk);
        chk("R11 err pulse", err, 0);
    endtask

    task automatic t_busy;
        bit ok; longint em, elo, ehi, ea;
        model(65000, 14318, 1000, 900000, 1, ok, em, elo, ehi, ea);
        fire(65000, 14318, 1000, 900000, 1);
        repeat (40) @(negedge clk);
        req = 20'd5000; fref = 20'd1000; cls = 2'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R12 busy");
        chk("R12 m byte", m_reg, em);
        chk("R12 n low", n_lo, elo);
        chk("R12 ach", ach, ea);
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0;
        req = '0; fref = '0; vmin = '0; fmax = '0; cls = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_tie;
        t_prescale;
        t_wide;
        t_clamp;
        t_general;
        t_error;
        t_busy;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule